// File: doc/BRIEF.md
# Boundary-Scan Pad Interception Register

This block sits between the functional core and the IO pad ring of a chip. It covers a configurable set of pins, and each pin is one of four kinds: input only, output only, output with a tristate enable, or bidirectional with a direction enable. The block creates scan cells only for the signals that a pin's kind actually has. Each intercepted signal gets two cells. One faces the pad and one faces the core. With this split, test equipment can exercise the pad while the core is faulty, and the core while the pad is faulty.

When `scan_mode` is low, every pad signal is wired combinationally to its core counterpart, and the scan cells have no influence. When `scan_mode` is high, the outputs change source:
- Pad-side outputs (`pad_out`, `pad_oe`) are driven by pad-side update latches.
- The core-side input (`core_in`) is driven by a core-side update latch.

In the same mode, the capture strobe samples the pad input level, the core output and the core enable into their own cells.

The controller that owns the test access state machine and instruction decode supplies four decoded strobes: `capture_en`, `shift_en`, `update_en` and `scan_mode`. All state advances on rising edges of the slow test clock `tck`, so no behaviour depends on that clock's frequency. The serial path is a plain bit stream paced by `shift_en`. There is no handshake on it: the controller owns the pacing, and the block never stalls.

Top module: `bsr_chain`

## Requirements
- R1: Pin i's kind is `PIN_KINDS[2i+1:2i]`, encoded as 0 input, 1 output, 2 tristate output, 3 bidirectional. Chain bit 0 is nearest `tdi`. Pins are laid out in index order. Within a pin, the pad-side cells (input, output, enable, where present) come first, then the core-side cells in the same order. With the default kinds {0,1,2,3}, this places the cells as follows:
  - Pin 0: 0 pad-in, 1 core-in.
  - Pin 1: 2 pad-out, 3 core-out.
  - Pin 2: 4 pad-out, 5 pad-oe, 6 core-out, 7 core-oe.
  - Pin 3: 8 pad-in, 9 pad-out, 10 pad-oe, 11 core-in, 12 core-out, 13 core-oe.
- R2: With `scan_mode` low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe` on pins that have those signals. `core_in` equals `pad_in` on pins that have an input. All three paths are combinational.
- R3: Signals absent from a pin's kind are held at fixed values in both modes:
  - `pad_out` is 0 on input-only pins.
  - `pad_oe` is 0 on input-only pins and 1 on output-only pins.
  - `core_in` is 0 on pins without an input.
- R4: With `scan_mode` high, `pad_out`, `pad_oe` and `core_in` take the update-latch values of their cells (pad-out, pad-oe and core-in respectively).
- R5: A capture edge has two effects:
  - The pad-in, core-out and core-oe cells load `pad_in`, `core_out` and `core_oe`.
  - Each driving cell (pad-out, pad-oe, core-in) loads its own update-latch value.
- R6: A shift edge moves `tdi` into bit 0 and each bit k into bit k+1. `tdo` is the last bit. `tdo` changes only on a capture or shift edge.
- R7: Update latches change only on an edge with `update_en` high, where they copy the shift stage. In scan mode, the driven outputs stay steady while the chain is shifted.
- R8: Reset (`rst_n` low, asynchronous) clears every shift cell and every update latch. In scan mode during or after reset, a scan-driven `pad_oe` is therefore 0 and the pad is released.
- R9: When `capture_en` and `shift_en` are both high on one edge, capture takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_mode | input | 1 | 1 selects scan-cell sourcing, 0 selects pass-through |
| shift_en | input | 1 | Shift the chain one place on this edge |
| capture_en | input | 1 | Parallel-load sampled values on this edge |
| update_en | input | 1 | Copy the shift stage into the update latches |
| tdi | input | 1 | Serial data into chain bit 0 |
| tdo | output | 1 | Serial data from the last chain bit |
| core_out | input | NUM_PINS | Output value from the core, per pin |
| core_oe | input | NUM_PINS | Output enable from the core, per pin |
| core_in | output | NUM_PINS | Input value delivered to the core, per pin |
| pad_in | input | NUM_PINS | Level sensed at the pad, per pin |
| pad_out | output | NUM_PINS | Value driven to the pad, per pin |
| pad_oe | output | NUM_PINS | Pad driver enable, per pin |

## Verification
The bench sweeps every combination of the twelve functional inputs in pass-through mode. A swapped or missing bypass, or a wrong tie-off on an absent signal, shows up as a wrong pad or core value.

All 128 patterns of the seven driving cells are loaded and checked on the pins before and after the update strobe. A design that drove outputs from the shift stage would show values rippling before the update. A miswired chain position would drive the wrong pin.

Capture is swept over 64 input patterns and read back serially. This catches a pad cell and a core cell that share one bit, or a reversed chain order. A final pass raises capture and shift together and then resets with scan mode held, which exposes a wrong strobe priority or a latch that survives reset.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Pin kind codes (two bits per pin in PIN_KINDS)
  localparam logic [1:0] KIND_IN    = 2'd0;
  localparam logic [1:0] KIND_OUT   = 2'd1;
  localparam logic [1:0] KIND_TRI   = 2'd2;
  localparam logic [1:0] KIND_BIDIR = 2'd3;

  // Cell roles, listed in chain order within a pin
  localparam int ROLE_PAD_IN   = 0;
  localparam int ROLE_PAD_OUT  = 1;
  localparam int ROLE_PAD_OE   = 2;
  localparam int ROLE_CORE_IN  = 3;
  localparam int ROLE_CORE_OUT = 4;
  localparam int ROLE_CORE_OE  = 5;
  localparam int NUM_ROLES     = 6;

  function automatic bit kind_has_in(input logic [1:0] kind);
    return (kind == KIND_IN) || (kind == KIND_BIDIR);
  endfunction

  function automatic bit kind_has_out(input logic [1:0] kind);
    return kind != KIND_IN;
  endfunction

  function automatic bit kind_has_oe(input logic [1:0] kind);
    return (kind == KIND_TRI) || (kind == KIND_BIDIR);
  endfunction

  function automatic bit role_present(input logic [1:0] kind, input int role);
    case (role)
      ROLE_PAD_IN,  ROLE_CORE_IN:  return kind_has_in(kind);
      ROLE_PAD_OUT, ROLE_CORE_OUT: return kind_has_out(kind);
      default:                     return kind_has_oe(kind);
    endcase
  endfunction

  // A driving cell owns an update latch that feeds a multiplexer
  function automatic bit role_drives(input int role);
    return (role == ROLE_PAD_OUT) || (role == ROLE_PAD_OE) || (role == ROLE_CORE_IN);
  endfunction

  function automatic int cell_count(input logic [1:0] kind);
    int n = 0;
    for (int r = 0; r < NUM_ROLES; r++)
      if (role_present(kind, r)) n++;
    return n;
  endfunction

  // Role of the idx-th cell of a pin of this kind
  function automatic int role_at(input logic [1:0] kind, input int idx);
    int n = 0;
    for (int r = 0; r < NUM_ROLES; r++) begin
      if (role_present(kind, r)) begin
        if (n == idx) return r;
        n++;
      end
    end
    return 0;
  endfunction

  // Cell index that carries a given role within a pin
  function automatic int role_index(input logic [1:0] kind, input int role);
    int n = 0;
    for (int r = 0; r < role; r++)
      if (role_present(kind, r)) n++;
    return n;
  endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
  parameter bit DRIVE = 1'b0
) (
  input  logic tck,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic si,
  input  logic cap_d,
  output logic sq,
  output logic uq
);

  // Shift stage: capture outranks shift
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          sq <= 1'b0;
    else if (capture_en) sq <= cap_d;
    else if (shift_en)   sq <= si;
  end

  generate
    if (DRIVE) begin : g_latch
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)         uq <= 1'b0;
        else if (update_en) uq <= sq;
      end
    end else begin : g_nolatch
      assign uq = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bsr_pin.sv
module bsr_pin
  import bsr_pkg::*;
#(
  parameter logic [1:0] KIND = KIND_BIDIR
) (
  input  logic tck,
  input  logic rst_n,
  input  logic scan_mode,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic si,
  output logic so,
  input  logic core_out,
  input  logic core_oe,
  output logic core_in,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe
);

  localparam int  NB      = cell_count(KIND);
  localparam bit  HAS_IN  = kind_has_in(KIND);
  localparam bit  HAS_OUT = kind_has_out(KIND);
  localparam bit  HAS_OE  = kind_has_oe(KIND);

  logic [NB-1:0] sq;
  logic [NB-1:0] uq;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_cell
      localparam int ROLE = role_at(KIND, k);
      localparam bit DRV  = role_drives(ROLE);
      logic cell_si;
      logic cell_cap;

      if (k == 0) begin : g_head
        assign cell_si = si;
      end else begin : g_link
        assign cell_si = sq[k-1];
      end

      if (DRV) begin : g_readback
        assign cell_cap = uq[k];
      end else if (ROLE == ROLE_PAD_IN) begin : g_obs_pad
        assign cell_cap = pad_in;
      end else if (ROLE == ROLE_CORE_OUT) begin : g_obs_out
        assign cell_cap = core_out;
      end else begin : g_obs_oe
        assign cell_cap = core_oe;
      end

      bsr_cell #(.DRIVE(DRV)) i_cell (
        .tck        (tck),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .si         (cell_si),
        .cap_d      (cell_cap),
        .sq         (sq[k]),
        .uq         (uq[k])
      );
    end

    if (HAS_OUT) begin : g_out
      localparam int IDX = role_index(KIND, ROLE_PAD_OUT);
      assign pad_out = scan_mode ? uq[IDX] : core_out;
    end else begin : g_no_out
      assign pad_out = 1'b0;
    end

    if (HAS_OE) begin : g_oe
      localparam int IDX = role_index(KIND, ROLE_PAD_OE);
      assign pad_oe = scan_mode ? uq[IDX] : core_oe;
    end else begin : g_no_oe
      assign pad_oe = HAS_OUT;
    end

    if (HAS_IN) begin : g_in
      localparam int IDX = role_index(KIND, ROLE_CORE_IN);
      assign core_in = scan_mode ? uq[IDX] : pad_in;
    end else begin : g_no_in
      assign core_in = 1'b0;
    end
  endgenerate

  assign so = sq[NB-1];

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int                    NUM_PINS  = 4,
  parameter logic [2*NUM_PINS-1:0] PIN_KINDS = {KIND_BIDIR, KIND_TRI, KIND_OUT, KIND_IN}
) (
  input  logic                tck,
  input  logic                rst_n,
  input  logic                scan_mode,
  input  logic                shift_en,
  input  logic                capture_en,
  input  logic                update_en,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] core_in,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  logic [NUM_PINS:0] link;

  assign link[0] = tdi;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam logic [1:0] KIND = PIN_KINDS[2*i +: 2];
      bsr_pin #(.KIND(KIND)) i_pin (
        .tck        (tck),
        .rst_n      (rst_n),
        .scan_mode  (scan_mode),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .si         (link[i]),
        .so         (link[i+1]),
        .core_out   (core_out[i]),
        .core_oe    (core_oe[i]),
        .core_in    (core_in[i]),
        .pad_in     (pad_in[i]),
        .pad_out    (pad_out[i]),
        .pad_oe     (pad_oe[i])
      );
    end
  endgenerate

  assign tdo = link[NUM_PINS];

endmodule

// File: rtl/bsr_chain_checker.sv
module bsr_chain_checker #(
  parameter int NUM_PINS = 4
) (
  input logic                tck,
  input logic                rst_n,
  input logic                scan_mode,
  input logic                shift_en,
  input logic                capture_en,
  input logic                update_en,
  input logic                tdo,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] core_in
);

  // R7: scan-driven pad value holds unless an update edge occurred
  a_r7_pad_out_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (scan_mode && !update_en) |=> (!scan_mode || $stable(pad_out)));

  // R7: scan-driven enable holds unless an update edge occurred
  a_r7_pad_oe_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (scan_mode && !update_en) |=> (!scan_mode || $stable(pad_oe)));

  // R7: scan-driven core input holds unless an update edge occurred
  a_r7_core_in_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (scan_mode && !update_en) |=> (!scan_mode || $stable(core_in)));

  // R6: serial output moves only on shift or capture edges
  a_r6_tdo_quiet: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(tdo));

  // R8: while reset is held, scan mode drives nothing
  always @(posedge tck) begin
    if (!rst_n && scan_mode) begin
      a_r8_reset_clear: assert ((pad_out == '0) && (core_in == '0) && (tdo == 1'b0));
    end
  end

endmodule

bind bsr_chain bsr_chain_checker #(.NUM_PINS(NUM_PINS)) i_bsr_chain_checker (
  .tck        (tck),
  .rst_n      (rst_n),
  .scan_mode  (scan_mode),
  .shift_en   (shift_en),
  .capture_en (capture_en),
  .update_en  (update_en),
  .tdo        (tdo),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .core_in    (core_in)
);

// File: tb/test_bsr_chain.sv
`timescale 1ns/1ps
module test_bsr_chain;

  localparam int          NP    = 4;
  localparam int          CLEN  = 14;
  localparam logic [7:0]  KINDS = 8'b11_10_01_00;
  localparam logic [13:0] DRV_MASK = 14'h0E36;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic scan_mode = 1'b0;
  logic shift_en = 1'b0;
  logic capture_en = 1'b0;
  logic update_en = 1'b0;
  logic tdi = 1'b0;
  wire  tdo;
  logic [NP-1:0] core_out = '0;
  logic [NP-1:0] core_oe = '0;
  logic [NP-1:0] pad_in = '0;
  wire  [NP-1:0] core_in;
  wire  [NP-1:0] pad_out;
  wire  [NP-1:0] pad_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 tck = ~tck;

  bsr_chain #(.NUM_PINS(NP), .PIN_KINDS(KINDS)) i_bsr_chain (
    .tck(tck), .rst_n(rst_n), .scan_mode(scan_mode), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2/R3 expected pins in pass-through: {core_in, pad_oe, pad_out}
  function automatic logic [11:0] exp_pass(input logic [3:0] co, input logic [3:0] oe,
                                           input logic [3:0] pi);
    logic [3:0] po, eo, ci;
    for (int i = 0; i < NP; i++) begin
      logic [1:0] k = KINDS[2*i +: 2];
      po[i] = (k != 2'd0) ? co[i] : 1'b0;
      eo[i] = (k >= 2'd2) ? oe[i] : (k != 2'd0);
      ci[i] = (k == 2'd0 || k == 2'd3) ? pi[i] : 1'b0;
    end
    return {ci, eo, po};
  endfunction

  // R1/R3/R4 expected pins in scan mode from latch image L
  function automatic logic [11:0] exp_scan(input logic [13:0] l);
    logic [3:0] po, eo, ci;
    po = {l[9], l[4], l[2], 1'b0};
    eo = {l[10], l[5], 1'b1, 1'b0};
    ci = {l[11], 1'b0, 1'b0, l[1]};
    return {ci, eo, po};
  endfunction

  // R1/R5 expected capture image
  function automatic logic [13:0] exp_cap(input logic [13:0] l, input logic [3:0] co,
                                          input logic [3:0] oe, input logic [3:0] pi);
    logic [13:0] c;
    c = l & DRV_MASK;
    c[0] = pi[0];  c[3] = co[1];  c[6] = co[2];  c[7] = oe[2];
    c[8] = pi[3];  c[12] = co[3]; c[13] = oe[3];
    return c;
  endfunction

  function automatic logic [13:0] place(input logic [6:0] p);
    logic [13:0] v = '0;
    v[1] = p[0]; v[2] = p[1]; v[4] = p[2]; v[5] = p[3];
    v[9] = p[4]; v[10] = p[5]; v[11] = p[6];
    return v;
  endfunction

  task automatic edge1();
    @(posedge tck);
    #1;
  endtask

  // Shift vin in (bit 13 first) while reading the old contents out
  task automatic shift_word(input logic [13:0] vin, output logic [13:0] vout);
    for (int c = 0; c < CLEN; c++) begin
      tdi = vin[CLEN-1-c];
      shift_en = 1'b1;
      vout[CLEN-1-c] = tdo;
      edge1();
    end
    shift_en = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic pulse_update();
    update_en = 1'b1;
    edge1();
    update_en = 1'b0;
  endtask

  task automatic pulse_capture();
    capture_en = 1'b1;
    edge1();
    capture_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [13:0] lat, prev, got, v;
    logic [3:0] co, oe, pi;
    lat = '0;
    prev = '0;

    // R8: reset state with scan mode on and busy functional inputs
    scan_mode = 1'b1;
    core_out = 4'hF; core_oe = 4'hF; pad_in = 4'hF;
    repeat (3) edge1();
    chk("R8 reset pins", {20'd0, core_in, pad_oe, pad_out}, {20'd0, exp_scan('0)});
    chk("R8 reset tdo", {31'd0, tdo}, 32'd0);
    rst_n = 1'b1;
    edge1();

    // R2/R3: exhaustive pass-through sweep
    scan_mode = 1'b0;
    for (int n = 0; n < 4096; n++) begin
      core_out = n[3:0]; core_oe = n[7:4]; pad_in = n[11:8];
      #1;
      chk("R2/R3 pass-through", {20'd0, core_in, pad_oe, pad_out},
          {20'd0, exp_pass(n[3:0], n[7:4], n[11:8])});
    end

    // R4/R6/R7: all driving-cell patterns through shift then update
    scan_mode = 1'b1;
    for (int p = 0; p < 128; p++) begin
      v = place(p[6:0]) ^ ({14{p[0]}} & ~DRV_MASK);
      core_out = p[3:0]; core_oe = p[6:3]; pad_in = ~p[3:0];
      shift_word(v, got);
      chk("R6 serial readback", {18'd0, got}, {18'd0, prev});
      prev = v;
      chk("R7 no ripple before update", {20'd0, core_in, pad_oe, pad_out}, {20'd0, exp_scan(lat)});
      pulse_update();
      lat = v & DRV_MASK;
      chk("R4 scan drive", {20'd0, core_in, pad_oe, pad_out}, {20'd0, exp_scan(lat)});
    end

    // R5: capture sweep, read out serially
    for (int q = 0; q < 64; q++) begin
      co = q[3:0]; oe = q[5:2]; pi = {q[0], q[5], q[1], q[4]};
      core_out = co; core_oe = oe; pad_in = pi;
      pulse_capture();
      shift_word('0, got);
      chk("R5 capture image", {18'd0, got}, {18'd0, exp_cap(lat, co, oe, pi)});
    end

    // R9: capture outranks shift on the same edge
    co = 4'b1010; oe = 4'b0110; pi = 4'b1001;
    core_out = co; core_oe = oe; pad_in = pi;
    capture_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
    edge1();
    capture_en = 1'b0; shift_en = 1'b0; tdi = 1'b0;
    shift_word('0, got);
    chk("R9 capture priority", {18'd0, got}, {18'd0, exp_cap(lat, co, oe, pi)});

    // R2: leaving scan mode restores pass-through despite loaded latches
    scan_mode = 1'b0;
    #1;
    chk("R2 bypass after scan", {20'd0, core_in, pad_oe, pad_out}, {20'd0, exp_pass(co, oe, pi)});

    // R8: reset clears latches and chain while scan mode is held
    scan_mode = 1'b1;
    shift_word(14'h3FFF, got);
    pulse_update();
    chk("R8 latches set", {20'd0, core_in, pad_oe, pad_out}, {20'd0, exp_scan(DRV_MASK)});
    rst_n = 1'b0;
    #2;
    chk("R8 reset releases pads", {20'd0, core_in, pad_oe, pad_out}, {20'd0, exp_scan('0)});
    chk("R8 reset clears tdo", {31'd0, tdo}, 32'd0);
    edge1();
    rst_n = 1'b1;
    edge1();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule